// File: doc/BRIEF.md
# Lane Low-Power / High-Speed Transition Sequencer

This block sequences a group of display serial lanes between the low-power idle state and high-speed burst transmission, and into and out of an ultra-low-power sleep state. It does not drive analog levels or serialize data. It decides when the lanes may switch mode, holds each switch for a programmable guard window, and raises a payload-enable strobe only once the high-speed capture window has settled.

A burst begins when the requester raises `burst_req`, provided the PLL is locked, every lane reports ready and the lane stop states agree. From the idle state `ST_LP`, the machine passes through `ST_ENTER`, `ST_STABLE`, `ST_BURST` and `ST_EXIT`, then returns to `ST_LP`. The requester ends the payload with `payload_done`. The machine enters the sleep state `ST_ULPS` only on an explicit `ulps_req` while every lane is stopped. It leaves sleep through `ST_RESUME`, a guard window that starts once the PLL is locked and that returns to `ST_LP`.

The named transitions are:
- `T_START`: LP→ENTER
- `T_SETTLE`: ENTER→STABLE
- `T_OPEN`: STABLE→BURST
- `T_CLOSE`: BURST→EXIT on `payload_done`
- `T_ABORT`: ENTER/STABLE/BURST→EXIT on loss of lock
- `T_IDLE`: EXIT→LP
- `T_SLEEP`: LP→ULPS
- `T_WAKE`: ULPS→RESUME
- `T_RETRY`: RESUME→RESUME on loss of lock
- `T_READY`: RESUME→LP

Each `T_ABORT` and each `T_RETRY` adds one to a saturating recovery counter.

Top module: `lane_mode_seq`

## Requirements
- R1: After reset the block is in LP: `link_idle`=1, and `lane_hs`, `lane_ulps`, `payload_en`, `incoherent` and `recovery_cnt` are all 0.
- R2: LP leaves for ENTER only on a clock edge at which all of the following hold: `burst_req`=1, `pll_locked`=1, every bit of `lane_ready`=1 and `incoherent`=0. While any of these is missing, `lane_hs` stays 0.
- R3: `lane_hs` is 1 in the ENTER, STABLE, BURST and EXIT states. The ENTER window lasts `win_enter`+1 cycles, the STABLE window lasts `win_stable`+1 cycles and the EXIT window lasts `win_exit`+1 cycles. Each length is taken from its input at the edge that starts the window, and a later change to that input has no effect on the running window.
- R4: `payload_en` is 1 only in BURST. Counting from the negedge at which `burst_req` is raised in LP with the gates met, `payload_en` is first seen 1 after `win_enter`+`win_stable`+3 clock edges.
- R5: Once EXIT has begun it runs to completion whatever the requests are. If `burst_req` is still held, the lanes spend exactly one cycle in LP (`lane_hs`=0) before entering again.
- R6: In LP, `incoherent`=1 whenever the bits of `lane_stop` are neither all 1 nor all 0. While this flag is 1, HS entry is blocked.
- R7: LP enters ULPS only when `ulps_req`=1, `burst_req`=0 and every `lane_stop` bit is 1. In ULPS, `lane_ulps`=1 and `burst_req` has no effect.
- R8: ULPS leaves for RESUME only when `resume_req`=1 and `pll_locked`=1. RESUME lasts `win_resume`+1 cycles with `lane_hs`=0 and then reaches LP. Measured from the request negedge, `link_idle` returns after `win_resume`+2 edges.
- R9: Losing `pll_locked` in ENTER, STABLE or BURST aborts to EXIT, using the normal EXIT window, and adds 1 to `recovery_cnt`. Losing lock in RESUME restarts the resume window and adds 1.
- R10: `recovery_cnt` changes only by +1 per cycle and holds at its all-ones maximum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| burst_req | input | 1 | Request for a high-speed burst |
| payload_done | input | 1 | End of payload, closes the burst |
| pll_locked | input | 1 | Reference PLL lock indication |
| lane_ready | input | NUM_LANES | Per-lane ready for HS |
| lane_stop | input | NUM_LANES | Per-lane stop-state indication |
| ulps_req | input | 1 | Request for ultra-low-power sleep |
| resume_req | input | 1 | Request to leave sleep |
| win_enter | input | WIN_W | HS entry window, in cycles minus one |
| win_stable | input | WIN_W | Stable-capture window, in cycles minus one |
| win_exit | input | WIN_W | HS exit window, in cycles minus one |
| win_resume | input | WIN_W | Resume guard window, in cycles minus one |
| link_idle | output | 1 | In the LP idle state |
| lane_hs | output | 1 | Lanes in high-speed mode |
| lane_ulps | output | 1 | Lanes in ultra-low-power mode |
| payload_en | output | 1 | Payload may be sent |
| incoherent | output | 1 | Lane stop states disagree while in LP |
| recovery_cnt | output | RCNT_W | Saturating count of aborts and retries |

## Verification
The bench builds the block with NUM_LANES=3, WIN_W=3 and RCNT_W=3. With a 3-bit window width, the sweep covers all 512 combinations of enter, stable and exit lengths, and all 8 resume lengths, including the zero-length windows. With three lanes, the bench can present stop patterns that are mixed without being all-equal. With a 3-bit recovery counter, a handful of forced lock losses is enough to drive the counter into saturation.

// File: rtl/lmseq_pkg.sv
package lmseq_pkg;
    typedef enum logic [2:0] {
        ST_LP     = 3'd0,
        ST_ENTER  = 3'd1,
        ST_STABLE = 3'd2,
        ST_BURST  = 3'd3,
        ST_EXIT   = 3'd4,
        ST_ULPS   = 3'd5,
        ST_RESUME = 3'd6
    } lm_state_t;
endpackage

// File: rtl/lmseq_window.sv
module lmseq_window #(
    parameter int WIN_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIN_W-1:0] load_val,
    output logic             expired
);
    logic [WIN_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/lmseq_lanes.sv
module lmseq_lanes #(
    parameter int NUM_LANES = 4
) (
    input  logic [NUM_LANES-1:0] lane_ready,
    input  logic [NUM_LANES-1:0] lane_stop,
    output logic                 all_ready,
    output logic                 all_stop,
    output logic                 stop_mixed
);
    logic [NUM_LANES:0] rdy_chain;
    logic [NUM_LANES:0] stp_chain;
    logic [NUM_LANES:0] any_chain;

    assign rdy_chain[0] = 1'b1;
    assign stp_chain[0] = 1'b1;
    assign any_chain[0] = 1'b0;

    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
        assign rdy_chain[i+1] = rdy_chain[i] & lane_ready[i];
        assign stp_chain[i+1] = stp_chain[i] & lane_stop[i];
        assign any_chain[i+1] = any_chain[i] | lane_stop[i];
    end

    assign all_ready  = rdy_chain[NUM_LANES];
    assign all_stop   = stp_chain[NUM_LANES];
    assign stop_mixed = any_chain[NUM_LANES] & ~stp_chain[NUM_LANES];
endmodule

// File: rtl/lmseq_recov.sv
module lmseq_recov #(
    parameter int RCNT_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bump,
    output logic [RCNT_W-1:0] count
);
    localparam logic [RCNT_W-1:0] MAXV = '1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (bump && count != MAXV)
            count <= count + 1'b1;
    end
endmodule

// File: rtl/lane_mode_seq.sv
module lane_mode_seq
    import lmseq_pkg::*;
#(
    parameter int NUM_LANES = 4,
    parameter int WIN_W     = 8,
    parameter int RCNT_W    = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 burst_req,
    input  logic                 payload_done,
    input  logic                 pll_locked,
    input  logic [NUM_LANES-1:0] lane_ready,
    input  logic [NUM_LANES-1:0] lane_stop,
    input  logic                 ulps_req,
    input  logic                 resume_req,
    input  logic [WIN_W-1:0]     win_enter,
    input  logic [WIN_W-1:0]     win_stable,
    input  logic [WIN_W-1:0]     win_exit,
    input  logic [WIN_W-1:0]     win_resume,
    output logic                 link_idle,
    output logic                 lane_hs,
    output logic                 lane_ulps,
    output logic                 payload_en,
    output logic                 incoherent,
    output logic [RCNT_W-1:0]    recovery_cnt
);
    lm_state_t        state, nxt;
    logic             win_load, win_expired, bump;
    logic [WIN_W-1:0] win_val;
    logic             all_ready, all_stop, stop_mixed;

    lmseq_lanes #(.NUM_LANES(NUM_LANES)) u_lanes (
        .lane_ready (lane_ready),
        .lane_stop  (lane_stop),
        .all_ready  (all_ready),
        .all_stop   (all_stop),
        .stop_mixed (stop_mixed)
    );

    lmseq_window #(.WIN_W(WIN_W)) u_win (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (win_load),
        .load_val (win_val),
        .expired  (win_expired)
    );

    lmseq_recov #(.RCNT_W(RCNT_W)) u_recov (
        .clk   (clk),
        .rst_n (rst_n),
        .bump  (bump),
        .count (recovery_cnt)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_LP;
        else
            state <= nxt;
    end

    // next state, window loads and recovery bumps
    always_comb begin
        nxt      = state;
        win_load = 1'b0;
        win_val  = '0;
        bump     = 1'b0;
        unique case (state)
            ST_LP: begin
                if (ulps_req && !burst_req && all_stop) begin
                    nxt = ST_ULPS;                                  // T_SLEEP
                end else if (burst_req && pll_locked && all_ready && !stop_mixed) begin
                    nxt = ST_ENTER; win_load = 1'b1; win_val = win_enter; // T_START
                end
            end
            ST_ENTER, ST_STABLE: begin
                if (!pll_locked) begin
                    nxt = ST_EXIT; win_load = 1'b1; win_val = win_exit; bump = 1'b1; // T_ABORT
                end else if (win_expired && state == ST_ENTER) begin
                    nxt = ST_STABLE; win_load = 1'b1; win_val = win_stable; // T_SETTLE
                end else if (win_expired) begin
                    nxt = ST_BURST;                                 // T_OPEN
                end
            end
            ST_BURST: begin
                if (!pll_locked) begin
                    nxt = ST_EXIT; win_load = 1'b1; win_val = win_exit; bump = 1'b1; // T_ABORT
                end else if (payload_done) begin
                    nxt = ST_EXIT; win_load = 1'b1; win_val = win_exit; // T_CLOSE
                end
            end
            ST_EXIT: begin
                if (win_expired) nxt = ST_LP;                       // T_IDLE
            end
            ST_ULPS: begin
                if (resume_req && pll_locked) begin
                    nxt = ST_RESUME; win_load = 1'b1; win_val = win_resume; // T_WAKE
                end
            end
            ST_RESUME: begin
                if (!pll_locked) begin
                    win_load = 1'b1; win_val = win_resume; bump = 1'b1; // T_RETRY
                end else if (win_expired) begin
                    nxt = ST_LP;                                    // T_READY
                end
            end
            default: nxt = ST_LP;
        endcase
    end

    // outputs
    always_comb begin
        link_idle  = 1'b0;
        lane_hs    = 1'b0;
        lane_ulps  = 1'b0;
        payload_en = 1'b0;
        incoherent = 1'b0;
        unique case (state)
            ST_LP: begin
                link_idle  = 1'b1;
                incoherent = stop_mixed;
            end
            ST_ENTER, ST_STABLE, ST_EXIT: lane_hs = 1'b1;
            ST_BURST: begin
                lane_hs    = 1'b1;
                payload_en = 1'b1;
            end
            ST_ULPS:   lane_ulps = 1'b1;
            ST_RESUME: ;
            default:   ;
        endcase
    end
endmodule

// File: rtl/lmseq_chk.sv
module lmseq_chk #(
    parameter int NUM_LANES = 4,
    parameter int RCNT_W    = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 burst_req,
    input logic                 pll_locked,
    input logic [NUM_LANES-1:0] lane_ready,
    input logic [NUM_LANES-1:0] lane_stop,
    input logic                 ulps_req,
    input logic                 link_idle,
    input logic                 lane_hs,
    input logic                 lane_ulps,
    input logic                 payload_en,
    input logic                 incoherent,
    input logic [RCNT_W-1:0]    recovery_cnt
);
    AST_ENTRY_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lane_hs) |-> $past(burst_req && pll_locked && (&lane_ready) && !incoherent && link_idle)); // R2
    AST_PAYLOAD_IN_HS: assert property (@(posedge clk) disable iff (!rst_n)
        payload_en |-> lane_hs); // R4
    AST_PAYLOAD_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(payload_en) |-> $past(pll_locked && lane_hs)); // R4
    AST_INCOH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        incoherent |=> !lane_hs); // R6
    AST_ULPS_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lane_ulps) |-> $past(ulps_req && (&lane_stop) && link_idle && !burst_req)); // R7
    AST_MODE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({lane_hs, lane_ulps, link_idle})); // R3
    AST_ULPS_NO_HS: assert property (@(posedge clk) disable iff (!rst_n)
        lane_ulps |=> !lane_hs); // R8
    AST_RCNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (recovery_cnt == $past(recovery_cnt) || recovery_cnt == $past(recovery_cnt) + 1'b1)); // R10
    AST_RCNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (&recovery_cnt) |=> (&recovery_cnt)); // R10
endmodule

bind lane_mode_seq lmseq_chk #(.NUM_LANES(NUM_LANES), .RCNT_W(RCNT_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .burst_req    (burst_req),
    .pll_locked   (pll_locked),
    .lane_ready   (lane_ready),
    .lane_stop    (lane_stop),
    .ulps_req     (ulps_req),
    .link_idle    (link_idle),
    .lane_hs      (lane_hs),
    .lane_ulps    (lane_ulps),
    .payload_en   (payload_en),
    .incoherent   (incoherent),
    .recovery_cnt (recovery_cnt)
);

// File: tb/tb_lane_mode_seq.sv
module tb_lane_mode_seq;
    localparam int NL = 3;
    localparam int WW = 3;
    localparam int RW = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic burst_req = 0, payload_done = 0, pll_locked = 0, ulps_req = 0, resume_req = 0;
    logic [NL-1:0] lane_ready = '0, lane_stop = '1;
    logic [WW-1:0] win_enter = '0, win_stable = '0, win_exit = '0, win_resume = '0;
    logic link_idle, lane_hs, lane_ulps, payload_en, incoherent;
    logic [RW-1:0] recovery_cnt;

    int nchk = 0, nbad = 0, exp_rc = 0;

    always #10 clk = ~clk;

    lane_mode_seq #(.NUM_LANES(NL), .WIN_W(WW), .RCNT_W(RW)) dut (.*);

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic tick;
        @(negedge clk);
    endtask

    // which: 0 payload_en==1, 1 lane_hs==0, 2 link_idle==1
    task automatic wait_for(input int which, output int n);
        n = 99;
        for (int k = 1; k <= 64; k++) begin
            tick();
            if ((which == 0 && payload_en) || (which == 1 && !lane_hs) ||
                (which == 2 && link_idle)) begin
                n = k;
                break;
            end
        end
    endtask

    task automatic bump_rc;
        exp_rc = (exp_rc < 7) ? exp_rc + 1 : 7;
    endtask

    initial begin
        int n, m;
        bit ok;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        chk(link_idle && !lane_hs && !lane_ulps && !payload_en && !incoherent && recovery_cnt == 0,
            "R1 reset state", {link_idle, lane_hs, lane_ulps, payload_en, incoherent}, 5'b10000);

        // R2 gating: no lock
        burst_req = 1; lane_ready = '1; pll_locked = 0;
        ok = 1; for (int k = 0; k < 6; k++) begin tick(); if (lane_hs) ok = 0; end
        chk(ok, "R2 no entry without lock", lane_hs, 0);
        pll_locked = 1; lane_ready = 3'b101;
        ok = 1; for (int k = 0; k < 6; k++) begin tick(); if (lane_hs) ok = 0; end
        chk(ok, "R2 no entry with a lane not ready", lane_hs, 0);
        // R6 incoherent stop states
        lane_ready = '1; lane_stop = 3'b011;
        ok = 1; for (int k = 0; k < 6; k++) begin tick(); if (lane_hs || !incoherent) ok = 0; end
        chk(ok, "R6 mixed stop flags and blocks", {incoherent, lane_hs}, 2'b10);
        lane_stop = 3'b000;
        tick();
        chk(lane_hs && !incoherent, "R6 all-zero stop is coherent, entry proceeds", {incoherent, lane_hs}, 2'b01);
        burst_req = 0; wait_for(0, n); payload_done = 1; tick(); payload_done = 0; wait_for(1, n);
        lane_stop = '1;

        // R3 R4 R5 window sweep
        for (int e = 0; e < 8; e++) for (int s = 0; s < 8; s++) for (int x = 0; x < 8; x++) begin
            win_enter = e[WW-1:0]; win_stable = s[WW-1:0]; win_exit = x[WW-1:0];
            burst_req = 1;
            tick(); n = 1;
            win_enter = ~e[WW-1:0];
            if (payload_en) m = 0; else wait_for(0, m);
            n += m;
            chk(n == e + s + 3, "R4 payload latency (R3 enter/stable windows)", n, e + s + 3);
            payload_done = 1; tick(); payload_done = 0; n = 1;
            win_exit = ~x[WW-1:0];
            wait_for(1, m); n += m;
            chk(n == x + 2, "R3 exit window length", n, x + 2);
            tick();
            chk(lane_hs == 1, "R5 single LP cycle then re-entry", lane_hs, 1);
            burst_req = 0;
            wait_for(0, m); payload_done = 1; tick(); payload_done = 0; wait_for(1, m);
        end

        // R9 lock loss in burst, repeated to saturate (R10)
        win_enter = 1; win_stable = 1; win_exit = 2;
        for (int i = 0; i < 9; i++) begin
            pll_locked = 1; burst_req = 1; wait_for(0, m); burst_req = 0;
            pll_locked = 0;
            wait_for(1, n);
            bump_rc();
            chk(n == 4, "R9 abort runs exit window", n, 4);
            chk(recovery_cnt == exp_rc, "R9 R10 recovery count", recovery_cnt, exp_rc);
        end
        chk(recovery_cnt == 7, "R10 saturated", recovery_cnt, 7);

        // R9 lock loss during ENTER
        pll_locked = 1; win_enter = 5; burst_req = 1; tick(); burst_req = 0;
        pll_locked = 0; wait_for(1, n);
        chk(n == 4 && recovery_cnt == 7, "R9 abort from entry window", n, 4);
        pll_locked = 1;

        // R7 ULPS entry
        lane_stop = 3'b110; ulps_req = 1;
        ok = 1; for (int k = 0; k < 4; k++) begin tick(); if (lane_ulps) ok = 0; end
        chk(ok, "R7 no sleep with lane not stopped", lane_ulps, 0);
        lane_stop = '1; tick();
        chk(lane_ulps && !link_idle, "R7 sleep entered", lane_ulps, 1);
        ulps_req = 0; burst_req = 1;
        ok = 1; for (int k = 0; k < 4; k++) begin tick(); if (lane_hs || !lane_ulps) ok = 0; end
        chk(ok, "R7 burst ignored in sleep", lane_hs, 0);
        burst_req = 0;

        // R8 resume needs lock
        pll_locked = 0; resume_req = 1;
        ok = 1; for (int k = 0; k < 4; k++) begin tick(); if (!lane_ulps) ok = 0; end
        chk(ok, "R8 stays asleep without lock", lane_ulps, 1);
        pll_locked = 1; resume_req = 0;

        // R8 resume guard sweep
        for (int r = 0; r < 8; r++) begin
            win_resume = r[WW-1:0]; resume_req = 1;
            ok = 1; n = 99;
            for (int k = 1; k <= 20; k++) begin
                tick(); resume_req = 0;
                if (lane_hs) ok = 0;
                if (link_idle) begin n = k; break; end
            end
            chk(n == r + 2 && ok, "R8 resume guard length", n, r + 2);
            ulps_req = 1; tick(); ulps_req = 0;
        end

        // R9 lock loss during resume
        exp_rc = 7;
        win_resume = 3; resume_req = 1; tick(); resume_req = 0;
        pll_locked = 0; tick(); pll_locked = 1;
        chk(!link_idle && !lane_ulps && recovery_cnt == 7, "R9 retry in resume", link_idle, 0);
        wait_for(2, n);
        chk(n == 4, "R9 resume guard restarted", n, 4);

        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        nchk++; nbad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", nchk, nbad);
        $finish;
    end
endmodule